// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one processor-side bus transfer at a time on a 20-bit address bus whose pins are shared. The lowest 8 address bits use the same lines as the 8-bit data path. The top 4 address bits use the same lines as a status nibble. A requester presents an address, write data, a read/write flag and a memory/I/O flag. The controller then steps through a fixed sequence of bus states. It first drives the address with an address-latch pulse. It then drives the read or write strobe together with the transceiver enable and direction pins. It returns a one-cycle completion pulse with the captured read data.

Every transfer passes through four base states, T1 to T4. A slow target stretches the transfer by holding the ready input low. Each low sample at the end of T3 or of a wait state adds one wait state with the same pin values as T3. An external latch captures the address on the latch pulse. An external transceiver takes its enable and direction from the controller. While no transfer runs, the strobes are inactive and the shared low byte is released.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the pins show the idle state: `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_den_n`=1, `bus_ad_oe`=0, `bus_io_m`=0, `bus_dt_r`=0 and `rsp_done`=0. In addition, `rsp_rdata` is cleared to zero.
- R2: A request with `req_valid` high in an idle cycle starts T1 in the next cycle. In T1, `bus_ale`=1, `bus_ad_oe`=1, `bus_ad_o`=addr[7:0], `bus_a_mid`=addr[15:8] and `bus_a_hi`=addr[19:16], and both strobes and `bus_den_n` are high. `bus_ale` is high for exactly one cycle.
- R3: From T2 through T4, `bus_a_hi` carries status: bit 0 is the I/O flag, bit 1 is the write flag, and bits 3:2 are zero. `bus_a_mid` keeps addr[15:8].
- R4: From T1 through T4, `bus_io_m` equals the I/O flag (1 = I/O, 0 = memory) and `bus_dt_r` equals the write flag (1 = toward the bus). Both values stay stable while `bus_den_n` is low. Both are 0 when idle.
- R5: A read drives `bus_rd_n` and `bus_den_n` low in T2, in T3 and in every wait state. It keeps `bus_ad_oe` low from T2 through T4.
- R6: A write drives `bus_wr_n` and `bus_den_n` low in T2, in T3 and in every wait state. It drives `bus_ad_o`=write data with `bus_ad_oe`=1 from T2 through T4.
- R7: `bus_ready` is sampled on the clock edge that ends T3, and on the edge that ends each wait state. Each low sample inserts one more wait state with the T3 pin values. A high sample moves to T4. A transfer therefore lasts 4 + (number of low samples) cycles.
- R8: For a read, `bus_ad_i` is captured on the edge that leaves T3 or a wait state with `bus_ready` high. `rsp_rdata` holds that value from T4 until the next read capture, and writes leave it unchanged.
- R9: `rsp_done` is high for exactly one cycle, in T4, once for each transfer. In T4 the strobes and `bus_den_n` are high. The cycle after T4 is idle.
- R10: `req_valid` is ignored while a transfer is in progress. No new T1 follows unless `req_valid` is high in an idle cycle.
- R11: Raising `rst` during a transfer aborts it. The next cycle shows the idle pins of R1, and no `rsp_done` pulse appears for the aborted transfer.
- R12: `bus_rd_n` and `bus_wr_n` are never low together. `bus_ale` is never high together with a low strobe or a low `bus_den_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, held for at least 4 clocks |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| rsp_rdata | output | 8 | Last captured read data |
| bus_ad_o | output | 8 | Shared low lines: address byte in T1, write data after |
| bus_ad_oe | output | 1 | Output enable of the shared low lines |
| bus_ad_i | input | 8 | Shared low lines as seen from the bus |
| bus_a_mid | output | 8 | Address bits 15:8 |
| bus_a_hi | output | 4 | Address bits 19:16 in T1, status from T2 to T4 |
| bus_ale | output | 1 | Address latch pulse, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io_m | output | 1 | 1 = I/O access, 0 = memory access |
| bus_dt_r | output | 1 | Transceiver direction, 1 = out of the controller |
| bus_den_n | output | 1 | Transceiver enable, active low |
| bus_ready | input | 1 | Target ready, low requests a wait state |

## Verification
The bench builds the block with its default widths: a 20-bit address, an 8-bit shared data byte and a 4-bit status nibble, which leaves 8 address bits on lines that are never shared. These values place the address byte, the held middle byte and the address-then-status nibble on separate pins. Each sharing rule can therefore be checked against its own address bits. The address patterns include all ones and all zeros, so a bit that is dropped at a field boundary shows up at the pins. The transfers cover zero, one, two and three wait states in both directions and in both address spaces. Requests held high during a transfer, and a reset raised in the middle of a strobe, cover the ignore and abort rules.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    // Bus state sequence of one transfer.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    // Status nibble bit positions, driven on the upper lines after T1.
    localparam int unsigned STAT_IO_BIT = 0;
    localparam int unsigned STAT_WR_BIT = 1;

endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm
    import mbc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              bus_ready,
    output phase_e            phase_q,
    output phase_e            phase_d,
    output logic [ADDR_W-1:0] addr_d,
    output logic [DATA_W-1:0] wdata_d,
    output logic              write_d,
    output logic              write_q,
    output logic              io_d
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              io;
    } seq_t;

    seq_t s_d;
    seq_t s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase = PH_T1;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.write = req_write;
                    s_d.io    = req_io;
                end
            end
            PH_T1:        s_d.phase = PH_T2;
            PH_T2:        s_d.phase = PH_T3;
            PH_T3, PH_TW: s_d.phase = bus_ready ? PH_T4 : PH_TW;
            PH_T4:        s_d.phase = PH_IDLE;
            default:      s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_q = s_q.phase;
    assign phase_d = s_d.phase;
    assign addr_d  = s_d.addr;
    assign wdata_d = s_d.wdata;
    assign write_d = s_d.write;
    assign write_q = s_q.write;
    assign io_d    = s_d.io;

endmodule

// File: rtl/mbc_pin_drv.sv
module mbc_pin_drv
    import mbc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STAT_W = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  phase_e                          phase_d,
    input  logic [ADDR_W-1:0]               addr_d,
    input  logic [DATA_W-1:0]               wdata_d,
    input  logic                            write_d,
    input  logic                            io_d,
    output logic [DATA_W-1:0]               ad_o,
    output logic                            ad_oe,
    output logic [ADDR_W-DATA_W-STAT_W-1:0] a_mid,
    output logic [STAT_W-1:0]               a_hi,
    output logic                            ale,
    output logic                            rd_n,
    output logic                            wr_n,
    output logic                            io_m,
    output logic                            dt_r,
    output logic                            den_n
);

    localparam int unsigned MID_W  = ADDR_W - DATA_W - STAT_W;
    localparam int unsigned HI_LSB = ADDR_W - STAT_W;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic              den_n;
        logic              dt_r;
        logic              io_m;
        logic              ad_oe;
        logic [DATA_W-1:0] ad;
        logic [MID_W-1:0]  mid;
        logic [STAT_W-1:0] hi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{
        ale:   1'b0,
        rd_n:  1'b1,
        wr_n:  1'b1,
        den_n: 1'b1,
        dt_r:  1'b0,
        io_m:  1'b0,
        ad_oe: 1'b0,
        ad:    '0,
        mid:   '0,
        hi:    '0
    };

    logic [STAT_W-1:0] stat;

    // Status nibble: one flag per assigned position, zero elsewhere.
    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == STAT_IO_BIT) begin : g_io
            assign stat[b] = io_d;
        end else if (b == STAT_WR_BIT) begin : g_wr
            assign stat[b] = write_d;
        end else begin : g_zero
            assign stat[b] = 1'b0;
        end
    end

    pins_t p_d;
    pins_t p_q;

    always_comb begin
        p_d = PINS_IDLE;
        if (phase_d != PH_IDLE) begin
            p_d.dt_r = write_d;
            p_d.io_m = io_d;
            p_d.mid  = addr_d[HI_LSB-1:DATA_W];
            p_d.hi   = stat;
        end
        unique case (phase_d)
            PH_T1: begin
                p_d.ale   = 1'b1;
                p_d.ad_oe = 1'b1;
                p_d.ad    = addr_d[DATA_W-1:0];
                p_d.hi    = addr_d[ADDR_W-1:HI_LSB];
            end
            PH_T2, PH_T3, PH_TW: begin
                p_d.den_n = 1'b0;
                p_d.rd_n  = write_d;
                p_d.wr_n  = !write_d;
                p_d.ad_oe = write_d;
                p_d.ad    = write_d ? wdata_d : '0;
            end
            PH_T4: begin
                p_d.ad_oe = write_d;
                p_d.ad    = write_d ? wdata_d : '0;
            end
            default: begin
                p_d.ale = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= PINS_IDLE;
        end else begin
            p_q <= p_d;
        end
    end

    assign ad_o  = p_q.ad;
    assign ad_oe = p_q.ad_oe;
    assign a_mid = p_q.mid;
    assign a_hi  = p_q.hi;
    assign ale   = p_q.ale;
    assign rd_n  = p_q.rd_n;
    assign wr_n  = p_q.wr_n;
    assign io_m  = p_q.io_m;
    assign dt_r  = p_q.dt_r;
    assign den_n = p_q.den_n;

endmodule

// File: rtl/mbc_rd_cap.sv
module mbc_rd_cap
    import mbc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_q,
    input  logic              write_q,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] rdata;
    } cap_t;

    cap_t c_d;
    cap_t c_q;
    logic finish;

    // The transfer phase ends on this edge when the target is ready.
    assign finish = ((phase_q == PH_T3) || (phase_q == PH_TW)) && bus_ready;

    always_comb begin
        c_d      = c_q;
        c_d.done = finish;
        if (finish && !write_q) begin
            c_d.rdata = bus_ad_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rdata = c_q.rdata;
    assign done  = c_q.done;

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STAT_W = 4,
    localparam int unsigned MID_W = ADDR_W - DATA_W - STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [MID_W-1:0]  bus_a_mid,
    output logic [STAT_W-1:0] bus_a_hi,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_io_m,
    output logic              bus_dt_r,
    output logic              bus_den_n,
    input  logic              bus_ready
);

    phase_e            phase_q;
    phase_e            phase_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d;
    logic              write_d;
    logic              write_q;
    logic              io_d;

    mbc_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_io    (req_io),
        .bus_ready (bus_ready),
        .phase_q   (phase_q),
        .phase_d   (phase_d),
        .addr_d    (addr_d),
        .wdata_d   (wdata_d),
        .write_d   (write_d),
        .write_q   (write_q),
        .io_d      (io_d)
    );

    mbc_pin_drv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAT_W (STAT_W)
    ) u_pins (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .addr_d  (addr_d),
        .wdata_d (wdata_d),
        .write_d (write_d),
        .io_d    (io_d),
        .ad_o    (bus_ad_o),
        .ad_oe   (bus_ad_oe),
        .a_mid   (bus_a_mid),
        .a_hi    (bus_a_hi),
        .ale     (bus_ale),
        .rd_n    (bus_rd_n),
        .wr_n    (bus_wr_n),
        .io_m    (bus_io_m),
        .dt_r    (bus_dt_r),
        .den_n   (bus_den_n)
    );

    mbc_rd_cap #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .phase_q   (phase_q),
        .write_q   (write_q),
        .bus_ready (bus_ready),
        .bus_ad_i  (bus_ad_i),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

endmodule

// File: rtl/mbc_chk.sv
module mbc_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dt_r,
    input logic io_m,
    input logic ad_oe,
    input logic done,
    input logic ready
);

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_ale_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        ale |-> (den_n && rd_n && wr_n));

    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!ad_oe && !den_n && !dt_r));

    p_write_drive_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (ad_oe && !den_n && dt_r));

    p_read_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !ready) |=> !rd_n);

    p_write_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !ready) |=> !wr_n);

    p_dir_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !den_n |-> ($stable(dt_r) && $stable(io_m)));

    p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(!rd_n || !wr_n));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && rd_n && wr_n && den_n));

endmodule

bind mux_bus_ctrl mbc_chk u_mbc_chk (
    .clk   (clk),
    .rst   (rst),
    .ale   (bus_ale),
    .rd_n  (bus_rd_n),
    .wr_n  (bus_wr_n),
    .den_n (bus_den_n),
    .dt_r  (bus_dt_r),
    .io_m  (bus_io_m),
    .ad_oe (bus_ad_oe),
    .done  (rsp_done),
    .ready (bus_ready)
);

// File: tb/mux_bus_ctrl_test.sv
module mux_bus_ctrl_test;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;
    localparam int STAT_W = 4;
    localparam int MID_W  = ADDR_W - DATA_W - STAT_W;

    // pin vector order: {ale, rd_n, wr_n, den_n, ad_oe}
    localparam logic [4:0] PV_IDLE = 5'b01110;
    localparam logic [4:0] PV_T1   = 5'b11111;
    localparam logic [4:0] PV_RD   = 5'b00100;
    localparam logic [4:0] PV_WR   = 5'b01001;
    localparam logic [4:0] PV_T4R  = 5'b01110;
    localparam logic [4:0] PV_T4W  = 5'b01111;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_write = 1'b0;
    logic              req_io = 1'b0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic [DATA_W-1:0] bus_ad_o;
    logic              bus_ad_oe;
    logic [DATA_W-1:0] bus_ad_i = '0;
    logic [MID_W-1:0]  bus_a_mid;
    logic [STAT_W-1:0] bus_a_hi;
    logic              bus_ale;
    logic              bus_rd_n;
    logic              bus_wr_n;
    logic              bus_io_m;
    logic              bus_dt_r;
    logic              bus_den_n;
    logic              bus_ready = 1'b1;

    always #4 clk = ~clk;

    mux_bus_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_io    (req_io),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .bus_ad_o  (bus_ad_o),
        .bus_ad_oe (bus_ad_oe),
        .bus_ad_i  (bus_ad_i),
        .bus_a_mid (bus_a_mid),
        .bus_a_hi  (bus_a_hi),
        .bus_ale   (bus_ale),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_io_m  (bus_io_m),
        .bus_dt_r  (bus_dt_r),
        .bus_den_n (bus_den_n),
        .bus_ready (bus_ready)
    );

    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    logic [DATA_W-1:0] last_rd = '0;
    logic [DATA_W-1:0] sb[$];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag, input string what, input logic [4:0] exp);
        chk(tag, what, {27'd0, bus_ale, bus_rd_n, bus_wr_n, bus_den_n, bus_ad_oe}, {27'd0, exp});
    endtask

    task automatic chk_idle(input string tag);
        chk_pins(tag, "idle pins", PV_IDLE);
        chk(tag, "idle io_m/dt_r", {bus_io_m, bus_dt_r}, 2'b00);
        chk(tag, "idle done", rsp_done, 1'b0);
    endtask

    // Monitor: pops the expected read data on each done pulse.
    always @(negedge clk) begin : monitor
        logic [DATA_W-1:0] e;
        if (!rst && rsp_done) begin
            if (sb.size() == 0) begin
                chk("R9", "done without a transfer", 1, 0);
            end else begin
                e = sb.pop_front();
                chk("R8", "rdata at done", rsp_rdata, e);
            end
        end
    end

    // Driver: runs one transfer, checks the pins state by state.
    task automatic do_cycle(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                            input bit wr, input bit io, input int nw,
                            input logic [DATA_W-1:0] rv, input bit noise);
        logic [STAT_W-1:0] st;
        logic [4:0]        xfer;
        st   = {2'b00, wr, io};
        xfer = wr ? PV_WR : PV_RD;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_wdata = wd;
        req_write = wr;
        req_io    = io;
        bus_ready = 1'b1;
        bus_ad_i  = rv;
        if (!wr) last_rd = rv;
        sb.push_back(last_rd);
        @(negedge clk);
        req_valid = 1'b0;
        // T1
        chk_pins("R2", "T1 pins", PV_T1);
        chk("R2", "T1 low byte", bus_ad_o, a[7:0]);
        chk("R2", "T1 mid byte", bus_a_mid, a[15:8]);
        chk("R2", "T1 upper nibble", bus_a_hi, a[19:16]);
        chk("R4", "T1 io_m/dt_r", {bus_io_m, bus_dt_r}, {io, wr});
        if (noise) begin
            req_valid = 1'b1;
            req_addr  = ~a;
        end
        bus_ready = (nw == 0);
        @(negedge clk);
        // T2
        chk_pins(wr ? "R6" : "R5", "T2 pins", xfer);
        chk("R3", "T2 status", bus_a_hi, st);
        chk("R3", "T2 mid byte", bus_a_mid, a[15:8]);
        chk("R4", "T2 io_m/dt_r", {bus_io_m, bus_dt_r}, {io, wr});
        if (wr) chk("R6", "T2 write data", bus_ad_o, wd);
        @(negedge clk);
        // T3
        chk_pins(wr ? "R6" : "R5", "T3 pins", xfer);
        chk("R9", "T3 no done", rsp_done, 1'b0);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            chk_pins("R7", "wait pins", xfer);
            chk("R7", "wait status", bus_a_hi, st);
            chk("R7", "wait no done", rsp_done, 1'b0);
            bus_ready = (i == nw - 1);
        end
        @(negedge clk);
        // T4
        chk("R9", "done in T4", rsp_done, 1'b1);
        chk_pins("R9", "T4 pins", wr ? PV_T4W : PV_T4R);
        chk("R3", "T4 status", bus_a_hi, st);
        if (wr) chk("R6", "T4 write data", bus_ad_o, wd);
        req_valid = 1'b0;
        bus_ad_i  = ~rv;
        @(negedge clk);
        chk_idle("R9");
        chk("R8", "rdata held", rsp_rdata, last_rd);
        @(negedge clk);
        chk("R10", "no stray T1", bus_ale, 1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk_idle("R1");
        chk("R1", "reset rdata", rsp_rdata, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        do_cycle(20'h94E21, 8'h00, 1'b0, 1'b0, 0, 8'h5A, 1'b0);
        do_cycle(20'h3C0A7, 8'hC3, 1'b1, 1'b1, 0, 8'h00, 1'b0);
        do_cycle(20'h600F0, 8'h00, 1'b0, 1'b1, 2, 8'hA6, 1'b1);
        do_cycle(20'hA1234, 8'h3E, 1'b1, 1'b0, 3, 8'h11, 1'b1);
        do_cycle(20'hFFFFF, 8'h00, 1'b0, 1'b0, 1, 8'hFF, 1'b0);

        // R11: reset raised while the read strobe is active
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 20'h12345;
        req_write = 1'b0;
        req_io    = 1'b0;
        bus_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_pins("R11", "strobe before abort", PV_RD);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R11");
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_ready = 1'b1;
        last_rd = '0;
        @(negedge clk);
        chk_idle("R11");
        chk("R1", "rdata cleared by reset", rsp_rdata, 0);

        do_cycle(20'h00000, 8'h00, 1'b0, 1'b0, 0, 8'h81, 1'b0);
        do_cycle(20'hFFFFF, 8'hFF, 1'b1, 1'b1, 1, 8'h00, 1'b0);

        repeat (3) @(negedge clk);
        chk("R9", "every transfer completed", sb.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule